// File: doc/BRIEF.md
# ADC Calibration and Conversion Sequencer

This block is the digital timing controller of a sigma-delta converter. It owns no arithmetic. It counts master clocks into modulator cycles and output-data periods, and from those counts it decides when a calibration step ends, when a capture of the zero-scale or full-scale point should happen, and when a fresh conversion result is in the data register. Three one-cycle strobes report these events to the filter and coefficient logic: `cap_zero`, `cap_full` and `result_vld`. The block also drives the active-low data-ready flag `drdy_n`.

A host starts a calibration with a setup write that carries a two-bit mode and a sync bit. Once the calibration finishes, the mode field returns to normal by itself. A separate control write sets or clears power-down. While powered down, the block keeps its state and delivers no new results, but a result that is already complete can still be read. After power-up, the first result comes after a fixed wake delay plus a settling conversion.

The output-data period P is `128 * odr_div` master clocks. A value of 0 on `odr_div` acts as 1. The period counter restarts on every accepted calibration command and at the end of the wake delay.

Top module: `adc_cal_sequencer`

## Requirements
- R1: While reset is held low, `drdy_n` is 1, `mode_q` is 00 and all strobes are 0. The first `result_vld` pulse comes exactly 3P clock edges after the last reset edge.
- R2: In normal running, a `result_vld` pulse and a falling `drdy_n` occur once every P clocks. P = 128 × `odr_div` (0 counts as 1), and `odr_div` is sampled freshly after a restart.
- R3: Mode codes are 00 normal, 01 self-calibration, 10 zero-scale system, 11 full-scale system. A setup write starts a calibration only if the mode is nonzero and sync is 0, and `mode_q` then shows the mode. Any other setup write changes neither `mode_q`, the result timing nor `drdy_n`.
- R4: Self-calibration (01) pulses `cap_zero` and `cap_full` together 6P after the command edge. `result_vld` follows at 9P, and `drdy_n` falls on that same edge.
- R5: Zero-scale system calibration (10) pulses only `cap_zero` at 3P, then `result_vld` at 4P.
- R6: Full-scale system calibration (11) pulses only `cap_full` at 3P, then `result_vld` at 4P.
- R7: `mode_q` returns to 00 on the same edge as the capture strobe that ends the calibration, and no result is flagged while the mode field is nonzero.
- R8: `drdy_n` falls only on a result. A `data_rd` pulse raises it on the next edge.
- R9: If `drdy_n` is 0 when a calibration command is accepted, it rises exactly 128 clocks after the command edge. If it is 1, it stays 1.
- R10: A calibration command accepted during a running calibration drops the old one; timing and strobes follow only the new command.
- R11: A control write with `comm_pd`=1 stops all strobes and keeps the `drdy_n` level. During power-down, `data_rd` still raises `drdy_n`, and setup writes are ignored.
- R12: A control write with `comm_pd`=0 during power-down yields the first `result_vld` exactly 2000 + 3P clocks after that write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| setup_wr | input | 1 | Setup-register write strobe |
| setup_mode | input | 2 | Mode field of the setup write |
| setup_sync | input | 1 | Sync bit of the setup write; 1 blocks calibration start |
| comm_wr | input | 1 | Control-register write strobe |
| comm_pd | input | 1 | Power-down bit of the control write |
| data_rd | input | 1 | Data-register read strobe |
| odr_div | input | ODR_W | Modulator cycles per output-data period |
| drdy_n | output | 1 | Active-low data-ready flag |
| mode_q | output | 2 | Current mode field |
| result_vld | output | 1 | One-cycle pulse: new result in the data register |
| cap_zero | output | 1 | One-cycle pulse: capture the zero-scale point |
| cap_full | output | 1 | One-cycle pulse: capture the full-scale point |

## Verification
The assertions watch the local invariants on every cycle. They check that `drdy_n` falls only on a result event and rises only on a read or a modulator-boundary re-arm. They also check that capture strobes coincide with the mode field clearing, that no result appears while a mode is pending, and that the rate and wake ticks never repeat on consecutive cycles. Only the bench scenarios can show the absolute durations: 3P, 4P, 6P and 9P from a command, the 128-clock re-arm, and 2000 + 3P after wake. They are also the only way to see an aborted calibration never firing its strobes, and a stored result surviving power-down. The scoreboard matches every strobe against its expected clock count.

// File: rtl/acs_pkg.sv
// Shared types for the calibration sequencer.
// Assumes: mode codes are fixed by the setup-register decode of the host.
package acs_pkg;

    typedef enum logic [2:0] {
        ST_RUN  = 3'd0,
        ST_CAL  = 3'd1,
        ST_CONV = 3'd2,
        ST_PD   = 3'd3,
        ST_WAKE = 3'd4
    } seq_state_t;

    typedef logic [1:0] mode_t;

    localparam mode_t MODE_NORMAL = 2'b00;
    localparam mode_t MODE_SELF   = 2'b01;
    localparam mode_t MODE_ZERO   = 2'b10;
    localparam mode_t MODE_FULL   = 2'b11;

endpackage

// File: rtl/acs_rate_gen.sv
// Modulator-cycle and output-data-rate tick generator.
// Counts MOD_CLKS master clocks per modulator cycle and odr_div modulator
// cycles per output period (0 treated as 1). A restart clears both counters.
// Assumes: restart is a single-cycle request from the sequencer.
module acs_rate_gen #(
    parameter int MOD_CLKS = 128,
    parameter int ODR_W    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [ODR_W-1:0] odr_div,
    output logic             mod_tick,
    output logic             odr_tick
);
    localparam int MC_W = $clog2(MOD_CLKS);
    localparam int PW   = ODR_W + 1;

    logic [MC_W-1:0]  mod_cnt;
    logic [ODR_W-1:0] per_cnt;
    logic             per_last;

    // Decode the end of a modulator cycle and of an output period.
    always_comb begin
        mod_tick = (mod_cnt == MC_W'(MOD_CLKS - 1));
        per_last = (PW'(per_cnt) + PW'(1)) >= PW'(odr_div);
        odr_tick = mod_tick && per_last;
    end

    // Advance the modulator and period counters, restarting on request.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            mod_cnt <= '0;
            per_cnt <= '0;
        end else begin
            mod_cnt <= mod_tick ? '0 : mod_cnt + 1'b1;
            if (mod_tick) begin
                per_cnt <= per_last ? '0 : per_cnt + 1'b1;
            end
        end
    end

    // R2
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mod_tick |=> !mod_tick);

    // R2
    odr_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
        odr_tick |-> (mod_tick && !$past(odr_tick)));

endmodule

// File: rtl/acs_wake_timer.sv
// Fixed power-up delay timer.
// Starts on wake_start, raises done for one cycle WAKE_CLKS clocks later.
// Assumes: wake_start does not repeat while the timer is running.
module acs_wake_timer #(
    parameter int WAKE_CLKS = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wake_start,
    output logic done
);
    localparam int WC_W = $clog2(WAKE_CLKS);

    logic [WC_W-1:0] cnt;
    logic            busy;

    // Flag the last clock of the delay.
    always_comb begin
        done = busy && (cnt == WC_W'(WAKE_CLKS - 1));
    end

    // Run the delay counter between start and done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (wake_start) begin
            busy <= 1'b1;
            cnt  <= '0;
        end else if (done) begin
            busy <= 1'b0;
        end else if (busy) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R12
    wake_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: rtl/acs_seq_ctrl.sv
// Calibration and conversion state machine.
// Accepts calibration commands and power-down writes, counts output periods
// for each calibration and settling conversion, and emits capture and result
// strobes. Assumes ticks come from acs_rate_gen and wake_done from the timer.
module acs_seq_ctrl
    import acs_pkg::*;
#(
    parameter int SELF_CAL_PER  = 6,
    parameter int SELF_CONV_PER = 3,
    parameter int SYS_CAL_PER   = 3,
    parameter int SYS_CONV_PER  = 1,
    parameter int WAKE_CONV_PER = 3
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  setup_wr,
    input  mode_t setup_mode,
    input  logic  setup_sync,
    input  logic  comm_wr,
    input  logic  comm_pd,
    input  logic  odr_tick,
    input  logic  wake_done,
    output logic  restart,
    output logic  wake_start,
    output logic  cmd_ok,
    output logic  res_evt,
    output mode_t mode_q,
    output logic  result_vld,
    output logic  cap_zero,
    output logic  cap_full
);
    localparam int MAX_A = (SELF_CAL_PER > SYS_CAL_PER) ? SELF_CAL_PER : SYS_CAL_PER;
    localparam int MAX_B = (SELF_CONV_PER > WAKE_CONV_PER) ? SELF_CONV_PER : WAKE_CONV_PER;
    localparam int MAX_P = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int REM_W = $clog2(MAX_P + 1);

    seq_state_t       state;
    logic [REM_W-1:0] rem;
    logic             awake;
    logic             pd_req;
    logic             cal_end;
    logic [REM_W-1:0] new_cal_len;
    logic [REM_W-1:0] pend_cal_len;
    logic [REM_W-1:0] conv_len;

    // Period counts for the mode being started, pending or finishing.
    always_comb begin
        new_cal_len  = (setup_mode == MODE_SELF) ? REM_W'(SELF_CAL_PER) : REM_W'(SYS_CAL_PER);
        pend_cal_len = (mode_q == MODE_SELF) ? REM_W'(SELF_CAL_PER) : REM_W'(SYS_CAL_PER);
        conv_len     = (mode_q == MODE_SELF) ? REM_W'(SELF_CONV_PER) : REM_W'(SYS_CONV_PER);
    end

    // Decode requests and the events of this cycle.
    always_comb begin
        awake      = (state == ST_RUN) || (state == ST_CAL) || (state == ST_CONV);
        pd_req     = comm_wr && comm_pd && awake;
        wake_start = comm_wr && !comm_pd && (state == ST_PD);
        cmd_ok     = setup_wr && (setup_mode != MODE_NORMAL) && !setup_sync
                     && awake && !pd_req;
        res_evt    = odr_tick && awake && !pd_req && !cmd_ok
                     && ((state == ST_RUN) || ((state == ST_CONV) && (rem == REM_W'(1))));
        cal_end    = odr_tick && !pd_req && !cmd_ok
                     && (state == ST_CAL) && (rem == REM_W'(1));
        restart    = cmd_ok || ((state == ST_WAKE) && wake_done);
    end

    // Register the one-cycle strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_vld <= 1'b0;
            cap_zero   <= 1'b0;
            cap_full   <= 1'b0;
        end else begin
            result_vld <= res_evt;
            cap_zero   <= cal_end && ((mode_q == MODE_SELF) || (mode_q == MODE_ZERO));
            cap_full   <= cal_end && ((mode_q == MODE_SELF) || (mode_q == MODE_FULL));
        end
    end

    // Sequence state, remaining-period count and mode field.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_CONV;
            rem    <= REM_W'(WAKE_CONV_PER);
            mode_q <= MODE_NORMAL;
        end else if (pd_req) begin
            state <= ST_PD;
        end else if (wake_start) begin
            state <= ST_WAKE;
        end else if (cmd_ok) begin
            state  <= ST_CAL;
            rem    <= new_cal_len;
            mode_q <= setup_mode;
        end else if ((state == ST_WAKE) && wake_done) begin
            if (mode_q != MODE_NORMAL) begin
                state <= ST_CAL;
                rem   <= pend_cal_len;
            end else begin
                state <= ST_CONV;
                rem   <= REM_W'(WAKE_CONV_PER);
            end
        end else if (odr_tick) begin
            case (state)
                ST_CAL: begin
                    if (rem == REM_W'(1)) begin
                        state  <= ST_CONV;
                        rem    <= conv_len;
                        mode_q <= MODE_NORMAL;
                    end else begin
                        rem <= rem - 1'b1;
                    end
                end
                ST_CONV: begin
                    if (rem == REM_W'(1)) begin
                        state <= ST_RUN;
                    end else begin
                        rem <= rem - 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // R7
    strobe_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_zero || cap_full) |-> (mode_q == MODE_NORMAL));

    // R7
    result_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        result_vld |-> (mode_q == MODE_NORMAL));

    // R11
    pd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_PD) |-> !(result_vld || cap_zero || cap_full));

endmodule

// File: rtl/acs_ready_flag.sv
// Active-low data-ready flag.
// Falls on a result, rises on a data read, and after a calibration command
// that found it low, rises at the next modulator boundary.
// Assumes: mod_tick restarts together with the command (shared restart).
module acs_ready_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic res_evt,
    input  logic data_rd,
    input  logic cal_cmd,
    input  logic mod_tick,
    output logic drdy_n
);
    logic pend;

    // Update the flag and the pending re-arm request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drdy_n <= 1'b1;
            pend   <= 1'b0;
        end else if (res_evt) begin
            drdy_n <= 1'b0;
            pend   <= 1'b0;
        end else if (data_rd) begin
            drdy_n <= 1'b1;
            pend   <= 1'b0;
        end else if (cal_cmd) begin
            pend <= !drdy_n;
        end else if (pend && mod_tick) begin
            drdy_n <= 1'b1;
            pend   <= 1'b0;
        end
    end

    // R8
    drdy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drdy_n) |-> $past(res_evt));

    // R9
    drdy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drdy_n) |-> $past(data_rd || (pend && mod_tick)));

endmodule

// File: rtl/adc_cal_sequencer.sv
// Top of the converter calibration and conversion sequencer.
// Ties the rate generator, wake timer, state machine and ready flag together.
// Assumes: host write and read strobes are single-cycle, synchronous to clk.
module adc_cal_sequencer
    import acs_pkg::*;
#(
    parameter int MOD_CLKS      = 128,
    parameter int ODR_W         = 8,
    parameter int WAKE_CLKS     = 2000,
    parameter int SELF_CAL_PER  = 6,
    parameter int SELF_CONV_PER = 3,
    parameter int SYS_CAL_PER   = 3,
    parameter int SYS_CONV_PER  = 1,
    parameter int WAKE_CONV_PER = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             setup_wr,
    input  logic [1:0]       setup_mode,
    input  logic             setup_sync,
    input  logic             comm_wr,
    input  logic             comm_pd,
    input  logic             data_rd,
    input  logic [ODR_W-1:0] odr_div,
    output logic             drdy_n,
    output logic [1:0]       mode_q,
    output logic             result_vld,
    output logic             cap_zero,
    output logic             cap_full
);
    logic restart;
    logic mod_tick;
    logic odr_tick;
    logic wake_start;
    logic wake_done;
    logic cmd_ok;
    logic res_evt;

    acs_rate_gen #(
        .MOD_CLKS (MOD_CLKS),
        .ODR_W    (ODR_W)
    ) u_rate (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (restart),
        .odr_div  (odr_div),
        .mod_tick (mod_tick),
        .odr_tick (odr_tick)
    );

    acs_wake_timer #(
        .WAKE_CLKS (WAKE_CLKS)
    ) u_wake (
        .clk        (clk),
        .rst_n      (rst_n),
        .wake_start (wake_start),
        .done       (wake_done)
    );

    acs_seq_ctrl #(
        .SELF_CAL_PER  (SELF_CAL_PER),
        .SELF_CONV_PER (SELF_CONV_PER),
        .SYS_CAL_PER   (SYS_CAL_PER),
        .SYS_CONV_PER  (SYS_CONV_PER),
        .WAKE_CONV_PER (WAKE_CONV_PER)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .setup_wr   (setup_wr),
        .setup_mode (setup_mode),
        .setup_sync (setup_sync),
        .comm_wr    (comm_wr),
        .comm_pd    (comm_pd),
        .odr_tick   (odr_tick),
        .wake_done  (wake_done),
        .restart    (restart),
        .wake_start (wake_start),
        .cmd_ok     (cmd_ok),
        .res_evt    (res_evt),
        .mode_q     (mode_q),
        .result_vld (result_vld),
        .cap_zero   (cap_zero),
        .cap_full   (cap_full)
    );

    acs_ready_flag u_rdy (
        .clk      (clk),
        .rst_n    (rst_n),
        .res_evt  (res_evt),
        .data_rd  (data_rd),
        .cal_cmd  (cmd_ok),
        .mod_tick (mod_tick),
        .drdy_n   (drdy_n)
    );

endmodule

// File: tb/adc_cal_sequencer_test.sv
// Scoreboard bench: scenario tasks push expected strobe codes and clock counts;
// a negedge monitor pops and compares them as strobes appear.
module adc_cal_sequencer_test;

    localparam int MODC = 128;
    localparam int P2   = MODC * 2;
    localparam int P3   = MODC * 3;
    localparam int WAKE = 2000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       setup_wr = 1'b0;
    logic [1:0] setup_mode = 2'b00;
    logic       setup_sync = 1'b0;
    logic       comm_wr = 1'b0;
    logic       comm_pd = 1'b0;
    logic       data_rd = 1'b0;
    logic [7:0] odr_div = 8'd2;
    logic       drdy_n;
    logic [1:0] mode_q;
    logic       result_vld;
    logic       cap_zero;
    logic       cap_full;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    int    q_code[$];
    int    q_when[$];
    string q_tag[$];

    adc_cal_sequencer uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .setup_wr   (setup_wr),
        .setup_mode (setup_mode),
        .setup_sync (setup_sync),
        .comm_wr    (comm_wr),
        .comm_pd    (comm_pd),
        .data_rd    (data_rd),
        .odr_div    (odr_div),
        .drdy_n     (drdy_n),
        .mode_q     (mode_q),
        .result_vld (result_vld),
        .cap_zero   (cap_zero),
        .cap_full   (cap_full)
    );

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", req, cyc, act, exp);
        end
    endtask

    task automatic push(input int code, input int when, input string tag);
        q_code.push_back(code);
        q_when.push_back(when);
        q_tag.push_back(tag);
    endtask

    // Monitor: strobe code = result 1, zero-capture 2, full-capture 4.
    always @(negedge clk) begin
        int code;
        if (rst_n) begin
            code = (result_vld ? 1 : 0) + (cap_zero ? 2 : 0) + (cap_full ? 4 : 0);
            if (code != 0) begin
                if (q_code.size() == 0) begin
                    chk(1'b0, "unexpected strobe", code, 0);
                end else begin
                    int    ec;
                    int    ew;
                    string et;
                    ec = q_code.pop_front();
                    ew = q_when.pop_front();
                    et = q_tag.pop_front();
                    chk(code == ec, et, code, ec);
                    chk(cyc == ew, et, cyc, ew);
                end
            end
        end
    end

    task automatic wait_until(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    task automatic cmd(input logic [1:0] m, input logic s, output int e);
        setup_mode = m;
        setup_sync = s;
        setup_wr   = 1'b1;
        e = cyc + 1;
        @(negedge clk);
        setup_wr = 1'b0;
    endtask

    task automatic ctl(input logic pd, output int e);
        comm_pd = pd;
        comm_wr = 1'b1;
        e = cyc + 1;
        @(negedge clk);
        comm_wr = 1'b0;
    endtask

    task automatic rd();
        data_rd = 1'b1;
        @(negedge clk);
        data_rd = 1'b0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired at cycle %0d: actual=hung expected=done", cyc);
            finish_run();
        end
    end

    initial begin
        int t;
        int e;
        int e2;
        int grid;
        repeat (5) @(negedge clk);
        // R1 reset state
        chk(drdy_n == 1'b1, "R1 drdy_n in reset", drdy_n, 1);
        chk(mode_q == 2'b00, "R1 mode_q in reset", mode_q, 0);
        chk({result_vld, cap_zero, cap_full} == 3'b000, "R1 strobes in reset",
            {result_vld, cap_zero, cap_full}, 0);
        rst_n = 1'b1;
        t = cyc;
        push(1, t + 3 * P2, "R1 first result");
        push(1, t + 4 * P2, "R2 periodic result");
        wait_until(t + 4 * P2 + 4);
        chk(drdy_n == 1'b0, "R2 drdy_n low after result", drdy_n, 0);
        rd();
        chk(drdy_n == 1'b1, "R8 read raises drdy_n", drdy_n, 1);

        // R4 self-calibration
        cmd(2'b01, 1'b0, e);
        chk(mode_q == 2'b01, "R3 mode_q shows self", mode_q, 1);
        push(6, e + 6 * P2, "R4 self capture");
        push(1, e + 9 * P2, "R4 self result");
        push(1, e + 10 * P2, "R2 run after self");
        wait_until(e + 6 * P2 - 1);
        chk(mode_q == 2'b01, "R7 mode held before end", mode_q, 1);
        wait_until(e + 6 * P2);
        chk(mode_q == 2'b00, "R7 mode cleared at end", mode_q, 0);
        wait_until(e + 9 * P2 - 1);
        chk(drdy_n == 1'b1, "R4 drdy_n high before 9P", drdy_n, 1);
        wait_until(e + 9 * P2);
        chk(drdy_n == 1'b0, "R4 drdy_n low at 9P", drdy_n, 0);
        wait_until(e + 10 * P2 + 4);

        // R5 zero-scale with drdy_n low at command (R9 re-arm)
        cmd(2'b10, 1'b0, e);
        push(2, e + 3 * P2, "R5 zero capture");
        push(1, e + 4 * P2, "R5 zero result");
        push(1, e + 5 * P2, "R2 run after zero");
        wait_until(e + 127);
        chk(drdy_n == 1'b0, "R9 drdy_n low before boundary", drdy_n, 0);
        wait_until(e + 128);
        chk(drdy_n == 1'b1, "R9 drdy_n high at boundary", drdy_n, 1);
        wait_until(e + 5 * P2 + 4);
        grid = e + 5 * P2;

        // R3 ignored writes: sync set, and mode 00
        cmd(2'b01, 1'b1, e);
        cmd(2'b00, 1'b0, e);
        chk(mode_q == 2'b00, "R3 ignored write keeps mode", mode_q, 0);
        push(1, grid + P2, "R3 run continues");
        push(1, grid + 2 * P2, "R3 run continues");
        wait_until(grid + P2 - 1);
        chk(drdy_n == 1'b0, "R3 ignored write keeps drdy_n", drdy_n, 0);
        wait_until(grid + 2 * P2 + 4);
        rd();

        // R6 full-scale with drdy_n high at command
        cmd(2'b11, 1'b0, e);
        chk(mode_q == 2'b11, "R3 mode_q shows full", mode_q, 3);
        push(4, e + 3 * P2, "R6 full capture");
        push(1, e + 4 * P2, "R6 full result");
        wait_until(e + 128);
        chk(drdy_n == 1'b1, "R9 drdy_n stays high", drdy_n, 1);
        wait_until(e + 4 * P2 + 4);

        // R10 abort self-calibration with zero-scale
        cmd(2'b01, 1'b0, e);
        wait_until(e + 2 * P2 + 5);
        cmd(2'b10, 1'b0, e2);
        chk(mode_q == 2'b10, "R10 new mode replaces old", mode_q, 2);
        push(2, e2 + 3 * P2, "R10 new capture only");
        push(1, e2 + 4 * P2, "R10 new result");
        wait_until(e2 + 4 * P2 + 4);

        // R11 power-down with a result waiting
        ctl(1'b1, e);
        chk(drdy_n == 1'b0, "R11 drdy_n kept at power-down", drdy_n, 0);
        cmd(2'b01, 1'b0, e);
        chk(mode_q == 2'b00, "R11 setup ignored in power-down", mode_q, 0);
        wait_until(e + 3 * P2);
        chk(drdy_n == 1'b0, "R11 drdy_n held low", drdy_n, 0);
        rd();
        chk(drdy_n == 1'b1, "R11 read in power-down", drdy_n, 1);

        // R12 wake-up
        ctl(1'b0, e);
        push(1, e + WAKE + 3 * P2, "R12 first result after wake");
        push(1, e + WAKE + 4 * P2, "R2 run after wake");
        wait_until(e + WAKE + 3 * P2 - 1);
        chk(drdy_n == 1'b1, "R12 drdy_n high before result", drdy_n, 1);
        wait_until(e + WAKE + 3 * P2);
        chk(drdy_n == 1'b0, "R12 drdy_n low at result", drdy_n, 0);
        wait_until(e + WAKE + 4 * P2 + 4);

        // R2 new rate divider applied after restart
        odr_div = 8'd3;
        cmd(2'b01, 1'b0, e);
        push(6, e + 6 * P3, "R2 self capture at new rate");
        push(1, e + 9 * P3, "R2 self result at new rate");
        wait_until(e + 9 * P3 + 4);
        ctl(1'b1, e);
        wait_until(e + 3 * P3);
        chk(q_code.size() == 0, "R11 all expected strobes seen", q_code.size(), 0);

        finished = 1'b1;
        finish_run();
    end

endmodule